// File: doc/BRIEF.md
# Weighted rank-difference combiner

This block sits behind a window sorter in an image filter pipeline. It takes nine samples that are already ordered by rank and subtracts each one from the top of the sample range. The result is a set of non-negative differences, one per rank. Each result channel has its own selection mask and its own set of small unsigned weights. A channel multiplies every difference that its mask selects by that rank's weight and adds the products together.

All channels work from the same set of differences in the same cycle. One datapath can therefore produce, for example, an inverted median and a weighted spread measure side by side. The filter function is set only by the masks and weights. These are loaded through a simple register-write port.

The datapath has two register stages. A build-time option selects the output form: either the full-width sum, which can never overflow, or a sum clipped to the sample width.

Top module: `rank_diff_combiner`

## Requirements
- R1: Sample k sits at bits [k*W +: W] of `in_samples`, with rank 0 in the lowest bits. Its difference is TOP - sample, where TOP = 2^W - 1.
- R2: A channel's result is the sum, over every rank k whose mask bit k is 1, of weight[k] times difference k. The weights are unsigned.
- R3: A channel whose mask is all zero produces a result of 0 for every sample set.
- R4: All channels compute from the same captured sample set at the same time. Each channel's result depends only on its own mask and weights.
- R5: If `in_valid` is high at rising edge n, `out_valid` is high after edge n+1, and the result for that sample set is present at the same time. `out_valid` is low in every other cycle.
- R6: A write (`cfg_we` high) to channel `cfg_ch` loads `cfg_wdata[N-1:0]` as that channel's mask when `cfg_is_mask` is 1. When `cfg_is_mask` is 0, it loads `cfg_wdata[WW-1:0]` as the weight of rank `cfg_idx`. A sample set captured on the same edge as a write still uses the old setting.
- R7: A weight write whose `cfg_idx` is N or higher changes no weight.
- R8: With SAT_EN = 0, each result is W+WW+clog2(N) bits wide. It holds the exact sum, including the largest case: all samples 0, all weights at their maximum, all ranks selected.
- R9: With SAT_EN = 1, each result is W bits wide and equals the exact sum, limited to TOP.
- R10: While `out_valid` is low, every result holds its previous value.
- R11: After reset, `out_valid` is 0, all results are 0, and all masks and weights are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks `in_samples` as a sample set to capture |
| in_samples | input | N*W | Nine rank-ordered samples, rank 0 in the lowest bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_is_mask | input | 1 | 1 writes a mask, 0 writes one weight |
| cfg_ch | input | clog2(CH) (min 1) | Channel addressed by the write |
| cfg_idx | input | clog2(N) | Rank whose weight is written |
| cfg_wdata | input | N | Mask value, or weight value in the low WW bits |
| out_valid | output | 1 | Results carry a new sample set |
| out_result | output | CH*OW | Channel results, channel 0 in the lowest bits |

## Verification
The bench first holds the masks empty, which separates correct zeroing from leakage of unselected ranks. It then selects one rank at weight 1, which exposes errors in rank position and in the subtraction. Mixed masks with unequal weights on two channels reveal products swapped between ranks or channels.

Samples of all zeros with every weight at its maximum test full-width growth against clipping. A write issued on the same edge as a capture tells apart the old and new settings. Writes to out-of-range indices show whether they corrupt real weights. A long random run with gaps in `in_valid` tests latency and hold behaviour.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

   typedef enum logic {
      CFG_WEIGHT = 1'b0,
      CFG_MASK   = 1'b1
   } cfg_kind_e;

   // bits of headroom needed to add n unsigned terms
   function automatic int unsigned growth_bits(input int unsigned n);
      return (n <= 1) ? 0 : $clog2(n);
   endfunction

endpackage

// File: rtl/rdc_diff.sv
module rdc_diff #(
   parameter int W = 8,
   parameter int N = 9
) (
   input  logic [N*W-1:0] in_samples,
   output logic [N*W-1:0] diff_o
);

   localparam logic [W-1:0] TOP = {W{1'b1}};

   for (genvar k = 0; k < N; k++) begin : g_rank
      assign diff_o[k*W +: W] = TOP - in_samples[k*W +: W];
   end

endmodule

// File: rtl/rdc_cfg_bank.sv
module rdc_cfg_bank
   import rdc_pkg::*;
#(
   parameter int N  = 9,
   parameter int CH = 2,
   parameter int WW = 4,
   localparam int IW = $clog2(N),
   localparam int CW = (CH > 1) ? $clog2(CH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  cfg_kind_e        cfg_kind_i,
   input  logic [CW-1:0]    cfg_ch,
   input  logic [IW-1:0]    cfg_idx,
   input  logic [N-1:0]     cfg_wdata,
   output logic [CH*N-1:0]  mask_o,
   output logic [CH*N*WW-1:0] weight_o
);

   for (genvar c = 0; c < CH; c++) begin : g_chan
      logic         ch_hit;
      logic [N-1:0] mask_q;

      assign ch_hit = cfg_we && (cfg_ch == CW'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q <= '0;
         end else if (ch_hit && cfg_kind_i == CFG_MASK) begin
            mask_q <= cfg_wdata;
         end
      end
      assign mask_o[c*N +: N] = mask_q;

      for (genvar k = 0; k < N; k++) begin : g_wt
         logic          wt_hit;
         logic [WW-1:0] wt_q;

         assign wt_hit = ch_hit && (cfg_kind_i == CFG_WEIGHT) && (cfg_idx == IW'(k));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wt_q <= '0;
            end else if (wt_hit) begin
               wt_q <= cfg_wdata[WW-1:0];
            end
         end
         assign weight_o[(c*N + k)*WW +: WW] = wt_q;
      end
   end

endmodule

// File: rtl/rdc_channel.sv
module rdc_channel
   import rdc_pkg::*;
#(
   parameter int W      = 8,
   parameter int N      = 9,
   parameter int WW     = 4,
   parameter bit SAT_EN = 1'b0,
   localparam int PW = W + WW,
   localparam int RW = W + WW + int'(growth_bits(N)),
   localparam int OW = SAT_EN ? W : RW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_s1,
   input  logic            load_s2,
   input  logic [N*W-1:0]  diff_i,
   input  logic [N-1:0]    mask_i,
   input  logic [N*WW-1:0] weight_i,
   output logic [OW-1:0]   result_o
);

   logic [N*PW-1:0] prod_flat;
   logic [RW-1:0]   sum_c;
   logic [OW-1:0]   res_c;
   logic [OW-1:0]   result_q;

   // stage 1: one gated product per rank
   for (genvar k = 0; k < N; k++) begin : g_term
      logic [PW-1:0] d_ext;
      logic [PW-1:0] w_ext;
      logic [PW-1:0] prod_c;
      logic [PW-1:0] prod_q;

      assign d_ext  = PW'(diff_i[k*W +: W]);
      assign w_ext  = PW'(weight_i[k*WW +: WW]);
      assign prod_c = mask_i[k] ? (d_ext * w_ext) : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prod_q <= '0;
         end else if (load_s1) begin
            prod_q <= prod_c;
         end
      end
      assign prod_flat[k*PW +: PW] = prod_q;
   end

   // stage 2: full-width accumulation
   always_comb begin
      sum_c = '0;
      for (int k = 0; k < N; k++) begin
         sum_c = sum_c + RW'(prod_flat[k*PW +: PW]);
      end
   end

   if (SAT_EN) begin : g_clip
      localparam logic [RW-1:0] TOP_EXT = RW'({W{1'b1}});
      assign res_c = (sum_c > TOP_EXT) ? {W{1'b1}} : sum_c[W-1:0];
   end else begin : g_full
      assign res_c = sum_c;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
      end else if (load_s2) begin
         result_q <= res_c;
      end
   end
   assign result_o = result_q;

endmodule

// File: rtl/rank_diff_combiner.sv
module rank_diff_combiner
   import rdc_pkg::*;
#(
   parameter int W      = 8,
   parameter int N      = 9,
   parameter int CH     = 2,
   parameter int WW     = 4,
   parameter bit SAT_EN = 1'b0,
   localparam int IW = $clog2(N),
   localparam int CW = (CH > 1) ? $clog2(CH) : 1,
   localparam int RW = W + WW + int'(growth_bits(N)),
   localparam int OW = SAT_EN ? W : RW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [N*W-1:0]   in_samples,
   input  logic             cfg_we,
   input  logic             cfg_is_mask,
   input  logic [CW-1:0]    cfg_ch,
   input  logic [IW-1:0]    cfg_idx,
   input  logic [N-1:0]     cfg_wdata,
   output logic             out_valid,
   output logic [CH*OW-1:0] out_result
);

   initial begin
      assert (W >= 2 && W <= 24) else $error("rank_diff_combiner: W out of range");
      assert (N >= 2) else $error("rank_diff_combiner: N must be at least 2");
      assert (CH >= 1) else $error("rank_diff_combiner: CH must be at least 1");
      assert (WW >= 1 && WW <= N) else $error("rank_diff_combiner: WW must fit in cfg_wdata");
   end

   logic [N*W-1:0]     diff_all;
   logic [CH*N-1:0]    mask_all;
   logic [CH*N*WW-1:0] weight_all;
   cfg_kind_e          cfg_kind;
   logic               v1_q;
   logic               v2_q;

   assign cfg_kind = cfg_kind_e'(cfg_is_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1_q <= 1'b0;
         v2_q <= 1'b0;
      end else begin
         v1_q <= in_valid;
         v2_q <= v1_q;
      end
   end
   assign out_valid = v2_q;

   rdc_diff #(.W(W), .N(N)) u_diff (
      .in_samples (in_samples),
      .diff_o     (diff_all)
   );

   rdc_cfg_bank #(.N(N), .CH(CH), .WW(WW)) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_we     (cfg_we),
      .cfg_kind_i (cfg_kind),
      .cfg_ch     (cfg_ch),
      .cfg_idx    (cfg_idx),
      .cfg_wdata  (cfg_wdata),
      .mask_o     (mask_all),
      .weight_o   (weight_all)
   );

   for (genvar c = 0; c < CH; c++) begin : g_out
      rdc_channel #(.W(W), .N(N), .WW(WW), .SAT_EN(SAT_EN)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .load_s1  (in_valid),
         .load_s2  (v1_q),
         .diff_i   (diff_all),
         .mask_i   (mask_all[c*N +: N]),
         .weight_i (weight_all[c*N*WW +: N*WW]),
         .result_o (out_result[c*OW +: OW])
      );
   end

endmodule

// File: rtl/rdc_checker.sv
module rdc_checker
   import rdc_pkg::*;
#(
   parameter int W      = 8,
   parameter int N      = 9,
   parameter int CH     = 2,
   parameter int WW     = 4,
   parameter bit SAT_EN = 1'b0,
   localparam int IW = $clog2(N),
   localparam int RW = W + WW + int'(growth_bits(N)),
   localparam int OW = SAT_EN ? W : RW
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             out_valid,
   input logic [CH*OW-1:0] out_result,
   input logic             cfg_we,
   input logic             cfg_is_mask,
   input logic [IW-1:0]    cfg_idx,
   input logic [CH*N-1:0]  mask_flat,
   input logic [CH*N*WW-1:0] weight_flat
);

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_rst <= '0;
      end else if (since_rst != 2'd3) begin
         since_rst <= since_rst + 2'd1;
      end
   end

   AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd0) |-> !out_valid); // R11

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R5

   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd1 && !out_valid) |-> $stable(out_result)); // R10

   AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_is_mask && int'(cfg_idx) >= N) |=> $stable(weight_flat)); // R7

   for (genvar c = 0; c < CH; c++) begin : g_chk
      AST_EMPTY_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (since_rst >= 2'd2 && out_valid && $past(mask_flat[c*N +: N], 2) == '0)
         |-> (out_result[c*OW +: OW] == '0)); // R3

      if (!SAT_EN) begin : g_bound
         localparam logic [OW-1:0] MAX_SUM = OW'(N * ((1 << W) - 1) * ((1 << WW) - 1));
         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (out_result[c*OW +: OW] <= MAX_SUM)); // R8
      end
   end

endmodule

bind rank_diff_combiner rdc_checker #(
   .W(W), .N(N), .CH(CH), .WW(WW), .SAT_EN(SAT_EN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .out_valid   (out_valid),
   .out_result  (out_result),
   .cfg_we      (cfg_we),
   .cfg_is_mask (cfg_is_mask),
   .cfg_idx     (cfg_idx),
   .mask_flat   (mask_all),
   .weight_flat (weight_all)
);

// File: tb/rank_diff_combiner_bench.sv
`timescale 1ns/1ps
module rank_diff_combiner_bench;

   localparam int W   = 8;
   localparam int N   = 9;
   localparam int CH  = 2;
   localparam int WW  = 4;
   localparam int TOP = 255;
   localparam int FW  = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [N*W-1:0] in_samples = '0;
   logic          cfg_we = 1'b0;
   logic          cfg_is_mask = 1'b0;
   logic          cfg_ch = 1'b0;
   logic [3:0]    cfg_idx = '0;
   logic [N-1:0]  cfg_wdata = '0;
   logic          out_valid_f, out_valid_s;
   logic [CH*FW-1:0] out_result_f;
   logic [CH*W-1:0]  out_result_s;

   always #10 clk = ~clk;

   rank_diff_combiner #(.W(W), .N(N), .CH(CH), .WW(WW), .SAT_EN(1'b0)) u_rank_diff_combiner (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
      .cfg_we(cfg_we), .cfg_is_mask(cfg_is_mask), .cfg_ch(cfg_ch), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .out_valid(out_valid_f), .out_result(out_result_f)
   );

   rank_diff_combiner #(.W(W), .N(N), .CH(CH), .WW(WW), .SAT_EN(1'b1)) u_rank_diff_combiner_sat (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_samples(in_samples),
      .cfg_we(cfg_we), .cfg_is_mask(cfg_is_mask), .cfg_ch(cfg_ch), .cfg_idx(cfg_idx),
      .cfg_wdata(cfg_wdata), .out_valid(out_valid_s), .out_result(out_result_s)
   );

   // ---------------- reference model ----------------
   int m_mask [CH];
   int m_wt   [CH][N];
   int s1_res [CH];
   bit s1_v;
   int e_res  [CH];
   bit e_v;

   int    n_checks = 0;
   int    n_fail   = 0;
   bit    done     = 1'b0;
   string phase_tag = "R11";

   function automatic int model_sum(input int c);
      int s = 0;
      for (int k = 0; k < N; k++) begin
         if ((m_mask[c] >> k) & 1)
            s += m_wt[c][k] * (TOP - int'(in_samples[k*W +: W]));
      end
      return s;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < CH; c++) begin
            m_mask[c] = 0; s1_res[c] = 0; e_res[c] = 0;
            for (int k = 0; k < N; k++) m_wt[c][k] = 0;
         end
         s1_v = 1'b0; e_v = 1'b0;
      end else begin
         if (s1_v) begin
            for (int c = 0; c < CH; c++) e_res[c] = s1_res[c];
         end
         e_v = s1_v;
         if (in_valid) begin
            for (int c = 0; c < CH; c++) s1_res[c] = model_sum(c);
         end
         s1_v = in_valid;
         if (cfg_we) begin
            if (cfg_is_mask) m_mask[cfg_ch] = int'(cfg_wdata);
            else if (int'(cfg_idx) < N) m_wt[cfg_ch][cfg_idx] = int'(cfg_wdata) & 15;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // compare on every cycle, away from the rising edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(out_valid_f == e_v, "R5", "out_valid full", int'(out_valid_f), int'(e_v));
         check(out_valid_s == e_v, "R5", "out_valid sat", int'(out_valid_s), int'(e_v));
         for (int c = 0; c < CH; c++) begin
            int act_f, act_s, exp_s;
            act_f = int'(out_result_f[c*FW +: FW]);
            act_s = int'(out_result_s[c*W +: W]);
            exp_s = (e_res[c] > TOP) ? TOP : e_res[c];
            check(act_f == e_res[c], e_v ? phase_tag : "R10",
                  $sformatf("ch%0d full result", c), act_f, e_res[c]);
            check(act_s == exp_s, "R9", $sformatf("ch%0d clipped result", c), act_s, exp_s);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic write_mask(input int c, input int m);
      cfg_we = 1'b1; cfg_is_mask = 1'b1; cfg_ch = c[0]; cfg_wdata = m[N-1:0];
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic write_wt(input int c, input int k, input int v);
      cfg_we = 1'b1; cfg_is_mask = 1'b0; cfg_ch = c[0]; cfg_idx = k[3:0]; cfg_wdata = v[N-1:0];
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic push(input logic [N*W-1:0] s);
      in_valid = 1'b1; in_samples = s;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [N*W-1:0] ramp(input int base, input int step);
      logic [N*W-1:0] v;
      for (int k = 0; k < N; k++) v[k*W +: W] = 8'((base + k*step) & 255);
      return v;
   endfunction

   // ---------------- test sequence ----------------
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: state right after reset
      check(out_valid_f == 1'b0, "R11", "out_valid after reset", int'(out_valid_f), 0);
      check(out_result_f == '0, "R11", "full results after reset", int'(out_result_f), 0);
      check(out_result_s == '0, "R11", "clipped results after reset", int'(out_result_s), 0);

      // R3: empty masks give zero whatever the samples
      phase_tag = "R3";
      push(ramp(0, 1)); push(ramp(200, 7)); idle(1); push(ramp(13, 29)); idle(3);

      // R1: single rank, unit weight exposes rank position and subtraction
      phase_tag = "R1";
      write_wt(0, 0, 1); write_mask(0, 9'h001);
      write_wt(1, 8, 1); write_mask(1, 9'h100);
      push(ramp(10, 20)); push(ramp(0, 31)); idle(3);

      // R2: several ranks with unequal weights
      phase_tag = "R2";
      for (int k = 0; k < N; k++) write_wt(0, k, k + 2);
      write_mask(0, 9'h155);
      push(ramp(5, 11)); push(ramp(100, 3)); idle(3);

      // R4: two channels with distinct settings on the same sample sets
      phase_tag = "R4";
      for (int k = 0; k < N; k++) write_wt(1, k, 15 - k);
      write_mask(1, 9'h0AA);
      push(ramp(40, 9)); push(ramp(250, 1)); push(ramp(77, 13)); idle(3);

      // R6: write on the same edge as a capture uses the old mask
      phase_tag = "R6";
      in_valid = 1'b1; in_samples = ramp(20, 5);
      cfg_we = 1'b1; cfg_is_mask = 1'b1; cfg_ch = 1'b0; cfg_wdata = 9'h003;
      @(negedge clk);
      cfg_we = 1'b0; in_samples = ramp(60, 4);
      @(negedge clk);
      in_valid = 1'b0; idle(3);

      // R7: out-of-range weight index must change nothing
      phase_tag = "R7";
      for (int k = N; k < 16; k++) write_wt(0, k, 9);
      for (int k = N; k < 16; k++) write_wt(1, k, 3);
      push(ramp(30, 17)); push(ramp(0, 0)); idle(3);

      // R8: largest possible sum, full width holds it, clip gives TOP
      phase_tag = "R8";
      for (int c = 0; c < CH; c++) begin
         for (int k = 0; k < N; k++) write_wt(c, k, 15);
         write_mask(c, 9'h1FF);
      end
      push('0); idle(3);

      // R9: sums around the clip level
      phase_tag = "R9";
      write_mask(0, 9'h001); write_wt(0, 0, 1);
      write_mask(1, 9'h003); write_wt(1, 0, 1); write_wt(1, 1, 1);
      push(ramp(255, 0)); push(ramp(128, 0)); push(ramp(200, 10)); idle(3);

      // R5 / R10: random traffic with gaps and interleaved writes
      phase_tag = "R5";
      for (int i = 0; i < 600; i++) begin
         in_valid = ($urandom_range(0, 2) != 0);
         for (int k = 0; k < N; k++) in_samples[k*W +: W] = 8'($urandom_range(0, 255));
         cfg_we = ($urandom_range(0, 5) == 0);
         cfg_is_mask = ($urandom_range(0, 3) == 0);
         cfg_ch = 1'($urandom_range(0, 1));
         cfg_idx = 4'($urandom_range(0, 15));
         cfg_wdata = 9'($urandom_range(0, 511));
         @(negedge clk);
      end
      in_valid = 1'b0; cfg_we = 1'b0;
      idle(4);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog run did not finish actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule